// File: doc/BRIEF.md
# Vector predicate mask lookup unit

This unit supplies the per-element predicate mask for a vector operation. It keeps two predication tables, one for integer-class and one for floating-point-class operand registers. Each table has one entry per register number, and each table has a companion bank of register-table enable flags. Software-visible configuration entries program the predication tables. A separate write port sets or clears the register-table flags.

A lookup names an operation class and a register number. A register with both its register-table flag and its predication entry active has a real predicate. For such a register the unit uses the entry's redirection index as the address on an integer register-file read port, and takes the returned word as the mask. The whole word is complemented when the entry asks for inversion. The entry's zeroing and fail-on-first bits are returned with the mask. Every other register gets a mask of all ones, with zeroing and fail-on-first both low.

The request side uses a valid/ready handshake. The register file is read in the request cycle, and the result appears one clock later. The result is held while the consumer stalls.

Top module: `predlk_unit`

## Requirements
- R1: After reset, `rsp_valid` is low, and every predication entry and register-table flag of both classes is inactive. Any lookup then returns `rsp_mask` all ones with `rsp_zero` = 0 and `rsp_ffirst` = 0.
- R2: A cycle with `cfg_we` = 1 writes the zero, invert, fail-on-first and redirection fields at register `cfg_reg` and marks that entry active. The target is the integer table when `cfg_type` = 0 and the floating-point table for any non-zero `cfg_type`. The write affects lookups accepted from the next cycle on.
- R3: A cycle with `rt_we` = 1 sets the register-table flag of class `rt_fp` (0 = integer, 1 = floating point) at register `rt_reg` to `rt_en`. It can both enable and disable the flag.
- R4: When the register-table flag of the requested register is clear, the result is an all-ones mask with zero and fail-on-first low. This holds even if the predication entry is active.
- R5: When the register-table flag is set but the predication entry is inactive, the result is an all-ones mask with zero and fail-on-first low.
- R6: When both are active, `rf_raddr` equals the entry's redirection index during the request cycle. The registered mask equals the `rf_rdata` seen in that cycle.
- R7: When the entry's invert bit is set, every bit of the fetched word is complemented in `rsp_mask`.
- R8: For a real predicate, `rsp_zero` and `rsp_ffirst` equal the entry's zero and fail-on-first bits.
- R9: `req_fp` = 0 consults only the integer tables and `req_fp` = 1 consults only the floating-point tables. The same register number can hold different settings in the two classes.
- R10: `req_ready` = !`rsp_valid` || `rsp_ready` once reset is released. An accepted request raises `rsp_valid` on the next cycle. While `rsp_valid` = 1 and `rsp_ready` = 0, the result holds stable.
- R11: A lookup accepted in the same cycle as a table or flag write sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Predication entry write strobe |
| cfg_type | input | TYPE_W | Entry type: 0 integer table, else floating-point table |
| cfg_reg | input | IDX_W | Register number of the entry |
| cfg_zero | input | 1 | Zeroing bit to store |
| cfg_inv | input | 1 | Invert bit to store |
| cfg_ffirst | input | 1 | Fail-on-first bit to store |
| cfg_predidx | input | IDX_W | Redirection index (integer register) to store |
| rt_we | input | 1 | Register-table flag write strobe |
| rt_fp | input | 1 | Flag class: 0 integer, 1 floating point |
| rt_reg | input | IDX_W | Register number of the flag |
| rt_en | input | 1 | Flag value to store |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_fp | input | 1 | Operation class: 0 integer, 1 floating point |
| req_reg | input | IDX_W | Requested operand register |
| rf_raddr | output | IDX_W | Integer register-file read address |
| rf_rdata | input | XLEN | Integer register-file read data (same cycle) |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_mask | output | XLEN | Predicate mask |
| rsp_zero | output | 1 | Zeroing flag |
| rsp_ffirst | output | 1 | Fail-on-first flag of the entry |

## Verification
The bench builds the unit with its defaults: a 64-bit mask, 32 registers per class and a 2-bit configuration type field. With a 2-bit type field, type codes 2 and 3 can be sent, which checks that any non-zero type selects the floating-point table. Thirty-two registers let a sweep reach both the lowest and the highest register and redirection index in each class. A 64-bit register file whose words differ in their upper halves catches a truncated or partly inverted mask.

// File: rtl/predlk_pkg.sv
package predlk_pkg;

  typedef enum logic {
    CLS_INT = 1'b0,
    CLS_FP  = 1'b1
  } op_class_e;

  typedef struct packed {
    logic zero;
    logic inv;
    logic ffirst;
  } pred_flags_t;

  localparam int unsigned NUM_CLASSES = 2;

endpackage

// File: rtl/predlk_rst_sync.sv
module predlk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/predlk_bank.sv
module predlk_bank
  import predlk_pkg::*;
#(
  parameter int unsigned NREG   = 32,
  parameter int unsigned IDX_W  = $clog2(NREG),
  parameter int unsigned TYPE_W = 2,
  parameter bit          IS_FP  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pw_we,
  input  logic [TYPE_W-1:0] pw_type,
  input  logic [IDX_W-1:0]  pw_reg,
  input  pred_flags_t       pw_flags,
  input  logic [IDX_W-1:0]  pw_idx,
  input  logic              rt_we,
  input  logic              rt_fp,
  input  logic [IDX_W-1:0]  rt_reg,
  input  logic              rt_en,
  input  logic [IDX_W-1:0]  rd_reg,
  output logic              rd_rt_en,
  output logic              rd_pen,
  output pred_flags_t       rd_flags,
  output logic [IDX_W-1:0]  rd_idx
);

  logic              pw_hit;
  logic              rt_hit;
  logic [NREG-1:0]   rt_q,  rt_d;
  logic [NREG-1:0]   pen_q, pen_d;
  pred_flags_t       flg_q [NREG];
  logic [IDX_W-1:0]  idx_q [NREG];

  // Type 0 names the integer table; every other code names the FP table.
  assign pw_hit = pw_we && (IS_FP ? (pw_type != '0) : (pw_type == '0));
  assign rt_hit = rt_we && (rt_fp == IS_FP);

  always_comb begin
    rt_d  = rt_q;
    pen_d = pen_q;
    if (rt_hit) rt_d[rt_reg]  = rt_en;
    if (pw_hit) pen_d[pw_reg] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_q  <= '0;
      pen_q <= '0;
    end else begin
      rt_q  <= rt_d;
      pen_q <= pen_d;
    end
  end

  // Payload fields need no reset: they are only read behind pen_q.
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (pw_hit && (pw_reg == IDX_W'(g))) begin
        flg_q[g] <= pw_flags;
        idx_q[g] <= pw_idx;
      end
    end
  end

  assign rd_rt_en = rt_q[rd_reg];
  assign rd_pen   = pen_q[rd_reg];
  assign rd_flags = flg_q[rd_reg];
  assign rd_idx   = idx_q[rd_reg];

  AST_PW_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pw_hit |=> (pen_q[$past(pw_reg)] && (idx_q[$past(pw_reg)] == $past(pw_idx))
                && (flg_q[$past(pw_reg)] == $past(pw_flags)))) else $error("pw"); // R2

  AST_RT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rt_hit |=> (rt_q[$past(rt_reg)] == $past(rt_en))) else $error("rt"); // R3

  AST_OTHER_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_we && (rt_fp != IS_FP) && !rt_hit) |=> $stable(rt_q)) else $error("cls"); // R9

endmodule

// File: rtl/predlk_resolve.sv
module predlk_resolve
  import predlk_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 5
) (
  input  logic              rt_en,
  input  logic              pen,
  input  pred_flags_t       flags,
  input  logic [IDX_W-1:0]  idx,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic [IDX_W-1:0]  rf_raddr,
  output logic              hit,
  output logic [XLEN-1:0]   mask,
  output logic              zero,
  output logic              ffirst
);

  always_comb begin
    hit      = rt_en && pen;
    rf_raddr = idx;
    if (hit) begin
      mask   = flags.inv ? ~rf_rdata : rf_rdata;
      zero   = flags.zero;
      ffirst = flags.ffirst;
    end else begin
      mask   = '1;
      zero   = 1'b0;
      ffirst = 1'b0;
    end
  end

endmodule

// File: rtl/predlk_unit.sv
module predlk_unit
  import predlk_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NREG   = 32,
  parameter int unsigned TYPE_W = 2,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TYPE_W-1:0] cfg_type,
  input  logic [IDX_W-1:0]  cfg_reg,
  input  logic              cfg_zero,
  input  logic              cfg_inv,
  input  logic              cfg_ffirst,
  input  logic [IDX_W-1:0]  cfg_predidx,
  input  logic              rt_we,
  input  logic              rt_fp,
  input  logic [IDX_W-1:0]  rt_reg,
  input  logic              rt_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_fp,
  input  logic [IDX_W-1:0]  req_reg,
  output logic [IDX_W-1:0]  rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [XLEN-1:0]   rsp_mask,
  output logic              rsp_zero,
  output logic              rsp_ffirst
);

  logic srst_n;

  predlk_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pred_flags_t      wr_flags;
  logic             bk_rt   [NUM_CLASSES];
  logic             bk_pen  [NUM_CLASSES];
  pred_flags_t      bk_flg  [NUM_CLASSES];
  logic [IDX_W-1:0] bk_idx  [NUM_CLASSES];

  assign wr_flags = '{zero: cfg_zero, inv: cfg_inv, ffirst: cfg_ffirst};

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_bank
    predlk_bank #(
      .NREG   (NREG),
      .IDX_W  (IDX_W),
      .TYPE_W (TYPE_W),
      .IS_FP  (c == int'(CLS_FP))
    ) u_bank (
      .clk      (clk),
      .rst_n    (srst_n),
      .pw_we    (cfg_we),
      .pw_type  (cfg_type),
      .pw_reg   (cfg_reg),
      .pw_flags (wr_flags),
      .pw_idx   (cfg_predidx),
      .rt_we    (rt_we),
      .rt_fp    (rt_fp),
      .rt_reg   (rt_reg),
      .rt_en    (rt_en),
      .rd_reg   (req_reg),
      .rd_rt_en (bk_rt[c]),
      .rd_pen   (bk_pen[c]),
      .rd_flags (bk_flg[c]),
      .rd_idx   (bk_idx[c])
    );
  end

  logic             sel_rt, sel_pen, hit;
  pred_flags_t      sel_flg;
  logic [IDX_W-1:0] sel_idx;
  logic [XLEN-1:0]  res_mask;
  logic             res_zero, res_ffirst;

  assign sel_rt  = bk_rt[req_fp];
  assign sel_pen = bk_pen[req_fp];
  assign sel_flg = bk_flg[req_fp];
  assign sel_idx = bk_idx[req_fp];

  predlk_resolve #(.XLEN(XLEN), .IDX_W(IDX_W)) u_res (
    .rt_en    (sel_rt),
    .pen      (sel_pen),
    .flags    (sel_flg),
    .idx      (sel_idx),
    .rf_rdata (rf_rdata),
    .rf_raddr (rf_raddr),
    .hit      (hit),
    .mask     (res_mask),
    .zero     (res_zero),
    .ffirst   (res_ffirst)
  );

  // Response register: next-state and register processes kept apart.
  logic            vld_q, vld_d;
  logic [XLEN-1:0] msk_q;
  logic            zro_q, ffs_q;
  logic            req_fire;

  assign req_ready = srst_n && (!vld_q || rsp_ready);
  assign req_fire  = req_valid && req_ready;

  always_comb begin
    vld_d = vld_q;
    if (req_fire)       vld_d = 1'b1;
    else if (rsp_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) vld_q <= 1'b0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (req_fire) begin
      msk_q <= res_mask;
      zro_q <= res_zero;
      ffs_q <= res_ffirst;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_mask   = msk_q;
  assign rsp_zero   = zro_q;
  assign rsp_ffirst = ffs_q;

  AST_FIRE_TO_VALID: assert property (@(posedge clk) disable iff (!srst_n)
    req_fire |=> rsp_valid) else $error("lat"); // R10

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_mask)
                                   && $stable(rsp_zero) && $stable(rsp_ffirst))) else $error("hold"); // R10

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    !rsp_valid |-> req_ready) else $error("rdy"); // R10

  AST_NO_RT_DEFAULT: assert property (@(posedge clk) disable iff (!srst_n)
    (req_fire && !sel_rt) |=> ((rsp_mask == '1) && !rsp_zero && !rsp_ffirst)) else $error("rt0"); // R4

  AST_NO_PRED_DEFAULT: assert property (@(posedge clk) disable iff (!srst_n)
    (req_fire && sel_rt && !sel_pen) |=> ((rsp_mask == '1) && !rsp_zero && !rsp_ffirst)) else $error("pen0"); // R5

  AST_PASS_MASK: assert property (@(posedge clk) disable iff (!srst_n)
    (req_fire && hit && !sel_flg.inv) |=> (rsp_mask == $past(rf_rdata))) else $error("pass"); // R6

  AST_INV_MASK: assert property (@(posedge clk) disable iff (!srst_n)
    (req_fire && hit && sel_flg.inv) |=> (rsp_mask == ~$past(rf_rdata))) else $error("inv"); // R7

  AST_FLAGS_OUT: assert property (@(posedge clk) disable iff (!srst_n)
    (req_fire && hit) |=> ((rsp_zero == $past(sel_flg.zero)) && (rsp_ffirst == $past(sel_flg.ffirst)))) else $error("flg"); // R8

endmodule

// File: tb/predlk_unit_tb_top.sv
module predlk_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN   = 64;
  localparam int NREG   = 32;
  localparam int TYPE_W = 2;
  localparam int IDX_W  = $clog2(NREG);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we, cfg_zero, cfg_inv, cfg_ffirst;
  logic [TYPE_W-1:0] cfg_type;
  logic [IDX_W-1:0]  cfg_reg, cfg_predidx;
  logic              rt_we, rt_fp, rt_en;
  logic [IDX_W-1:0]  rt_reg;
  logic              req_valid, req_ready, req_fp;
  logic [IDX_W-1:0]  req_reg, rf_raddr;
  logic [XLEN-1:0]   rf_rdata;
  logic              rsp_valid, rsp_ready, rsp_zero, rsp_ffirst;
  logic [XLEN-1:0]   rsp_mask;

  logic [XLEN-1:0] rf_mem [NREG];
  assign rf_rdata = rf_mem[rf_raddr];

  always #(CLK_PERIOD/2) clk = ~clk;

  predlk_unit #(.XLEN(XLEN), .NREG(NREG), .TYPE_W(TYPE_W)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_type, .cfg_reg, .cfg_zero, .cfg_inv, .cfg_ffirst,
    .cfg_predidx, .rt_we, .rt_fp, .rt_reg, .rt_en, .req_valid, .req_ready,
    .req_fp, .req_reg, .rf_raddr, .rf_rdata, .rsp_valid, .rsp_ready,
    .rsp_mask, .rsp_zero, .rsp_ffirst
  );

  // Behavioural reference state
  bit              m_rt  [2][NREG];
  bit              m_pen [2][NREG];
  bit              m_zero[2][NREG];
  bit              m_inv [2][NREG];
  bit              m_ff  [2][NREG];
  int              m_idx [2][NREG];
  bit              e_valid;
  logic [XLEN-1:0] e_mask;
  bit              e_zero, e_ff;

  int    total = 0, bad = 0;
  string tag = "R1";
  bit    finished = 0;

  task automatic chk(bit ok, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_we = 0; cfg_type = '0; cfg_reg = '0; cfg_zero = 0; cfg_inv = 0;
    cfg_ffirst = 0; cfg_predidx = '0; rt_we = 0; rt_fp = 0; rt_reg = '0;
    rt_en = 0; req_valid = 0; req_fp = 0; req_reg = '0; rsp_ready = 1;
  endtask

  // One clock: called just after a falling edge with inputs set.
  task automatic tick();
    int  c, r, k;
    bit  hit, rdy, fire;
    #1;
    c = int'(req_fp); r = int'(req_reg);
    hit = m_rt[c][r] && m_pen[c][r];
    rdy = !e_valid || rsp_ready;
    fire = req_valid && rdy;
    chk(req_ready == rdy, "req_ready", 64'(req_ready), 64'(rdy));
    if (req_valid && hit)
      chk(int'(rf_raddr) == m_idx[c][r], "rf_raddr", 64'(rf_raddr), 64'(m_idx[c][r]));
    @(posedge clk);
    if (fire) begin
      e_valid = 1;
      if (hit) begin
        e_mask = m_inv[c][r] ? ~rf_mem[m_idx[c][r]] : rf_mem[m_idx[c][r]];
        e_zero = m_zero[c][r]; e_ff = m_ff[c][r];
      end else begin
        e_mask = '1; e_zero = 0; e_ff = 0;
      end
    end else if (rsp_ready) e_valid = 0;
    if (cfg_we) begin
      k = (cfg_type != 0) ? 1 : 0;
      m_pen[k][cfg_reg] = 1; m_zero[k][cfg_reg] = cfg_zero;
      m_inv[k][cfg_reg] = cfg_inv; m_ff[k][cfg_reg] = cfg_ffirst;
      m_idx[k][cfg_reg] = int'(cfg_predidx);
    end
    if (rt_we) m_rt[rt_fp][rt_reg] = rt_en;
    @(negedge clk);
    chk(rsp_valid == e_valid, "rsp_valid", 64'(rsp_valid), 64'(e_valid));
    if (e_valid) begin
      chk(rsp_mask == e_mask, "rsp_mask", rsp_mask, e_mask);
      chk(rsp_zero == e_zero, "rsp_zero", 64'(rsp_zero), 64'(e_zero));
      chk(rsp_ffirst == e_ff, "rsp_ffirst", 64'(rsp_ffirst), 64'(e_ff));
    end
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    e_valid = 0;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < NREG; r++) begin
        m_rt[c][r] = 0; m_pen[c][r] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic lookup(bit fp, int r);
    req_valid = 1; req_fp = fp; req_reg = IDX_W'(r);
    tick();
    req_valid = 0;
  endtask

  task automatic prog(int typ, int r, bit z, bit inv, bit ff, int idx);
    cfg_we = 1; cfg_type = TYPE_W'(typ); cfg_reg = IDX_W'(r);
    cfg_zero = z; cfg_inv = inv; cfg_ffirst = ff; cfg_predidx = IDX_W'(idx);
    tick();
    cfg_we = 0;
  endtask

  task automatic set_rt(bit fp, int r, bit en);
    rt_we = 1; rt_fp = fp; rt_reg = IDX_W'(r); rt_en = en;
    tick();
    rt_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < NREG; i++)
      rf_mem[i] = (64'h9E37_79B9_7F4A_7C15 * 64'(i + 1)) ^ {32'(i), 32'hA5A5_0000 | 32'(i)};
    rf_mem[0] = '0;
    do_reset();

    tag = "R1";
    lookup(0, 3); lookup(1, 5); lookup(1, 31);

    tag = "R4";
    prog(0, 3, 1, 0, 1, 7);
    lookup(0, 3);

    tag = "R5";
    set_rt(1, 9, 1);
    lookup(1, 9);

    tag = "R6";
    set_rt(0, 3, 1);
    lookup(0, 3);

    tag = "R7";
    prog(0, 4, 0, 1, 1, 2);
    set_rt(0, 4, 1);
    lookup(0, 4);
    prog(0, 5, 1, 1, 0, 0);
    set_rt(0, 5, 1);
    lookup(0, 5);

    tag = "R2";
    prog(2, 3, 0, 0, 0, 10);
    set_rt(1, 3, 1);
    lookup(1, 3);
    prog(3, 31, 1, 1, 1, 31);
    set_rt(1, 31, 1);
    lookup(1, 31);

    tag = "R9";
    lookup(0, 3); lookup(1, 3);
    set_rt(1, 4, 1);
    lookup(1, 4);

    tag = "R8";
    lookup(0, 3); lookup(0, 4); lookup(1, 31);

    tag = "R3";
    set_rt(0, 3, 0);
    lookup(0, 3);
    set_rt(0, 3, 1);
    lookup(0, 3);

    tag = "R10";
    rsp_ready = 0;
    req_valid = 1; req_fp = 0; req_reg = 4;
    tick(); tick(); tick();
    rsp_ready = 1; tick();
    req_reg = 3; tick(); tick();
    req_valid = 0; tick(); tick();

    tag = "R11";
    prog(0, 6, 0, 0, 0, 12);
    req_valid = 1; req_fp = 0; req_reg = 6;
    rt_we = 1; rt_fp = 0; rt_reg = 6; rt_en = 1;
    tick();
    rt_we = 0;
    cfg_we = 1; cfg_type = 0; cfg_reg = 6; cfg_inv = 1; cfg_predidx = 13;
    tick();
    cfg_we = 0; cfg_inv = 0;
    tick();
    req_valid = 0; tick();

    tag = "R9";
    seed = 12345;
    for (int n = 0; n < 300; n++) begin
      seed = seed * 1103515245 + 12345;
      case ((seed >>> 16) & 3)
        0: begin
          cfg_we = 1; cfg_type = TYPE_W'(seed >>> 4); cfg_reg = IDX_W'(seed >>> 8);
          cfg_zero = seed[20]; cfg_inv = seed[21]; cfg_ffirst = seed[22];
          cfg_predidx = IDX_W'(seed >>> 24);
        end
        1: begin
          rt_we = 1; rt_fp = seed[5]; rt_reg = IDX_W'(seed >>> 9); rt_en = seed[23];
        end
        default: ;
      endcase
      req_valid = seed[25]; req_fp = seed[26]; req_reg = IDX_W'(seed >>> 3);
      rsp_ready = seed[29] | seed[30];
      tick();
      idle_inputs();
    end
    tick();

    tag = "R1";
    do_reset();
    lookup(0, 3); lookup(1, 31); lookup(0, 4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule